// File: doc/BRIEF.md
# Power Rail Start-Up Sequencer

This block is the control state machine of a power management device. Releasing power-on reset starts a timed copy of the non-volatile configuration into the register map. The copy is modelled as a fixed number of clock cycles. After it, the block either waits for a filtered ON request or starts rails at once, chosen by a first-supply-detect bit. Rails come up slot by slot. Each rail is checked for power-good within a timeout, and each rail's fault flag is watched.

When an attempt fails, the block drops every enabled rail, starting from the highest slot and working down. It waits a fixed settle time and then tries again. A configuration field sets the number of retries. When the retry budget is spent, the block stays in its initialize condition with a sticky lockout flag set. Only a new power-on reset clears this. A filtered release of the enable pin while all rails are up powers them down in the same reverse order.

Top module: `pwr_seq_fsm`

## Requirements
- R1: After `por_n` rises, the block spends exactly LOAD_CYC clock edges in the loading phase, with `state_code` = 0 and `rail_en` all zero. The first possible rail enable appears after the LOAD_CYC-th edge.
- R2: With `fsd_en` = 0 at the end of loading, no rail is enabled and `state_code` = 1 (initialize) until a filtered ON request arrives.
- R3: With `fsd_en` = 1 at the end of loading, the slot-0 rails are enabled on the LOAD_CYC-th edge without any ON request, and `state_code` = 2 (sequencing).
- R4: The enable pin is synchronised and then filtered in both directions. A level held for fewer than DGL_CYC cycles has no effect. A level held for DGL_CYC cycles or more is taken.
- R5: Rail r belongs to slot `rail_slot[2r+1:2r]`. Slots start in order 0,1,2,3. A slot starts only after every rail already enabled shows power-good and more than `slot_dly[8s+7:8s]` further cycles have passed. In the up state (`state_code` = 3) every rail is enabled.
- R6: An attempt fails when any enabled rail shows `rail_flt`, or when the enabled rails are not all power-good within PG_TMO cycles of a slot starting. `fault_rail` then holds the enabled rails that were faulted or not power-good.
- R7: On a failed attempt, the rails drop one slot per cycle from slot 3 down to slot 0. After SETTLE_CYC cycles the sequence restarts. The total number of attempts is `retry_max` + 1.
- R8: After the last failed attempt, `lockout` = 1, `state_code` = 1 and `rail_en` = 0. This holds while ON requests come in, and it clears only on `por_n` low.
- R9: In the up state, a filtered falling level on the enable pin drops all rails and returns to `state_code` = 1, and `lockout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| en_pin | input | 1 | Raw enable pin |
| pg | input | NRAIL | Per-rail power-good |
| rail_flt | input | NRAIL | Per-rail fault flag |
| fsd_en | input | 1 | Start without waiting for an ON request |
| retry_max | input | 2 | Retries after the first attempt |
| rail_slot | input | 2*NRAIL | Slot number per rail |
| slot_dly | input | 4*DLY_W | Delay per slot before the next slot |
| rail_en | output | NRAIL | Rail enables |
| state_code | output | 2 | 0 load, 1 initialize, 2 sequencing, 3 up |
| lockout | output | 1 | Sticky retry-exhausted flag |
| fault_rail | output | NRAIL | Rails blamed for the last failure |

## Verification
Sequencing is tried with all rails healthy, with one late-slot rail that never shows power-good, with an early rail whose fault flag is set, and with no rail ever good. These patterns separate a power-good timeout from a fault flag, and a fault in the first slot from one in the last slot, and the attempt counts show whether the retry field is honoured. Mixed slot assignments expose wrong start order and wrong reverse drop order. Enable pulses one cycle shorter than the filter time, in both directions, show whether the filter limit is off by one.

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm #(
  parameter int NRAIL      = 4,
  parameter int LOAD_CYC   = 40,
  parameter int DGL_CYC    = 5,
  parameter int PG_TMO     = 12,
  parameter int SETTLE_CYC = 8,
  parameter int DLY_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 en_pin,
  input  logic [NRAIL-1:0]     pg,
  input  logic [NRAIL-1:0]     rail_flt,
  input  logic                 fsd_en,
  input  logic [1:0]           retry_max,
  input  logic [2*NRAIL-1:0]   rail_slot,
  input  logic [4*DLY_W-1:0]   slot_dly,
  output logic [NRAIL-1:0]     rail_en,
  output logic [1:0]           state_code,
  output logic                 lockout,
  output logic [NRAIL-1:0]     fault_rail
);
  localparam int DG_W = $clog2(DGL_CYC + 1);

  typedef enum logic [2:0] {LOAD, INIT, RAMP, GAP, DOWN, SETTLE, UP, LOCK} st_t;
  st_t st;

  logic [1:0]       sy;
  logic [DG_W-1:0]  dg_cnt;
  logic             on_q, on_prev;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       slot, tries;
  logic             failed;
  logic [NRAIL-1:0] m_cur, m_nxt, m_zero;
  logic [DLY_W-1:0] dly_cur;

  always_comb
    for (int r = 0; r < NRAIL; r++) begin
      m_cur[r]  = rail_slot[2*r +: 2] == slot;
      m_nxt[r]  = rail_slot[2*r +: 2] == slot + 2'd1;
      m_zero[r] = rail_slot[2*r +: 2] == 2'd0;
    end

  assign dly_cur = slot_dly[slot*DLY_W +: DLY_W];

  wire flt_hit = |(rail_en & rail_flt);
  wire all_pg  = (pg & rail_en) == rail_en;
  wire on_fall = on_prev & ~on_q;

  assign state_code = (st == LOAD) ? 2'd0 :
                      (st == INIT || st == LOCK) ? 2'd1 :
                      (st == UP) ? 2'd3 : 2'd2;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sy <= '0; dg_cnt <= '0; on_q <= 1'b0; on_prev <= 1'b0;
    end else begin
      sy <= {sy[0], en_pin};
      on_prev <= on_q;
      if (sy[1] == on_q) dg_cnt <= '0;
      else if (dg_cnt == DG_W'(DGL_CYC - 1)) begin
        on_q <= sy[1]; dg_cnt <= '0;
      end else dg_cnt <= dg_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st <= LOAD; cnt <= '0; slot <= '0; tries <= '0; failed <= 1'b0;
      rail_en <= '0; lockout <= 1'b0; fault_rail <= '0;
    end else begin
      case (st)
        LOAD:
          if (cnt == CNT_W'(LOAD_CYC - 1)) begin
            cnt <= '0;
            if (fsd_en) begin
              st <= RAMP; slot <= '0; tries <= '0; rail_en <= m_zero;
            end else st <= INIT;
          end else cnt <= cnt + 1'b1;
        INIT:
          if (on_q) begin
            st <= RAMP; cnt <= '0; slot <= '0; tries <= '0; rail_en <= m_zero;
          end
        RAMP, GAP:
          if (flt_hit || (st == RAMP && !all_pg && cnt == CNT_W'(PG_TMO - 1))) begin
            fault_rail <= rail_en & (rail_flt | ~pg);
            failed <= 1'b1; st <= DOWN; slot <= 2'd3;
          end else if (st == RAMP) begin
            if (all_pg) begin st <= GAP; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end else if (cnt >= CNT_W'(dly_cur)) begin
            cnt <= '0;
            if (slot == 2'd3) st <= UP;
            else begin
              slot <= slot + 2'd1; rail_en <= rail_en | m_nxt; st <= RAMP;
            end
          end else cnt <= cnt + 1'b1;
        UP:
          if (on_fall) begin
            failed <= 1'b0; st <= DOWN; slot <= 2'd3;
          end
        DOWN: begin
          rail_en <= rail_en & ~m_cur;
          if (slot == 2'd0) begin st <= SETTLE; cnt <= '0; end
          else slot <= slot - 2'd1;
        end
        SETTLE:
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            if (!failed) st <= INIT;
            else if (tries == retry_max) begin st <= LOCK; lockout <= 1'b1; end
            else begin
              tries <= tries + 2'd1; rail_en <= m_zero; st <= RAMP;
            end
          end else cnt <= cnt + 1'b1;
        default: st <= LOCK;
      endcase
    end
endmodule

module pwr_seq_fsm_chk #(parameter int NRAIL = 4) (
  input logic             clk,
  input logic             por_n,
  input logic [NRAIL-1:0] rail_en,
  input logic [1:0]       state_code,
  input logic             lockout
);
  // R1
  load_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    state_code == 2'd0 |-> rail_en == '0);
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    lockout |=> lockout);
  // R8
  lock_dark_chk: assert property (@(posedge clk) disable iff (!por_n)
    lockout |-> rail_en == '0 && state_code == 2'd1);
  // R5
  up_all_chk: assert property (@(posedge clk) disable iff (!por_n)
    state_code == 2'd3 |-> &rail_en);
  // R9
  up_leave_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rail_en[0]) && !lockout |-> state_code != 2'd3);
endmodule

bind pwr_seq_fsm pwr_seq_fsm_chk #(.NRAIL(NRAIL)) u_chk (
  .clk(clk), .por_n(por_n), .rail_en(rail_en),
  .state_code(state_code), .lockout(lockout));

// File: tb/sim_pwr_seq_fsm.sv
`timescale 1ns/1ps
module sim_pwr_seq_fsm;
  localparam int N = 4, LOAD = 40, DGL = 5;
  logic clk = 0, por_n = 0, en_pin = 0, fsd_en = 0;
  logic [1:0] retry_max = 0;
  logic [N-1:0] pg, rail_flt, rail_en, fault_rail, pg_ok = '1, flt_mask = '0, d1;
  logic [1:0] state_code;
  logic lockout;
  logic [2*N-1:0] rail_slot = {2'd1, 2'd3, 2'd0, 2'd2};
  logic [31:0] slot_dly = {8'd3, 8'd4, 8'd5, 8'd6};
  int checks = 0, errors = 0, cyc = 0, att = 0;
  int rise_t [N], fall_t [N];
  logic [N-1:0] prev;

  always #2.5 clk = ~clk;

  pwr_seq_fsm u0 (.clk(clk), .por_n(por_n), .en_pin(en_pin), .pg(pg),
    .rail_flt(rail_flt), .fsd_en(fsd_en), .retry_max(retry_max),
    .rail_slot(rail_slot), .slot_dly(slot_dly), .rail_en(rail_en),
    .state_code(state_code), .lockout(lockout), .fault_rail(fault_rail));

  assign rail_flt = rail_en & flt_mask;
  always @(posedge clk) begin
    d1 <= rail_en & pg_ok; pg <= d1; cyc <= cyc + 1; prev <= rail_en;
    if (!por_n) att <= 0;
    else if (rail_en[1] && !prev[1]) att <= att + 1;
    for (int r = 0; r < N; r++) begin
      if (rail_en[r] && !prev[r]) rise_t[r] <= cyc;
      if (!rail_en[r] && prev[r]) fall_t[r] <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_por;
    @(negedge clk); por_n = 0; cyc_n(3); por_n = 1;
  endtask

  // fsd, retry, pg_ok, flt_mask, exp_code, exp_lock, exp_att, exp_frail
  localparam logic [20:0] VEC [6] = '{
    {1'b1, 2'd2, 4'b1111, 4'b0000, 2'd3, 1'b0, 3'd1, 4'b0000},
    {1'b1, 2'd2, 4'b1011, 4'b0000, 2'd1, 1'b1, 3'd3, 4'b0100},
    {1'b1, 2'd1, 4'b1111, 4'b0010, 2'd1, 1'b1, 3'd2, 4'b0010},
    {1'b0, 2'd0, 4'b1111, 4'b0000, 2'd1, 1'b0, 3'd0, 4'b0000},
    {1'b1, 2'd3, 4'b0000, 4'b0000, 2'd1, 1'b1, 3'd4, 4'b0010},
    {1'b1, 2'd0, 4'b1011, 4'b0000, 2'd1, 1'b1, 3'd1, 4'b0100}
  };

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc_n(2);
    chk(rail_en == 0 && state_code == 0 && lockout == 0, "R1 reset", rail_en, 0);
    // R1 / R3: exact load length
    fsd_en = 1; pg_ok = '1; flt_mask = '0;
    @(negedge clk); por_n = 1;
    cyc_n(LOAD - 1);
    chk(rail_en == 0 && state_code == 0, "R1 load", state_code, 0);
    cyc_n(1);
    chk(rail_en == 4'b0010 && state_code == 2, "R3 fsd start", rail_en, 2);

    for (int i = 0; i < 6; i++) begin
      logic [20:0] v;
      v = VEC[i];
      fsd_en = v[20]; retry_max = v[19:18]; pg_ok = v[17:14]; flt_mask = v[13:10];
      do_por();
      cyc_n(1500);
      chk(state_code == v[9:8], $sformatf("R6 R7 case%0d code", i), state_code, v[9:8]);
      chk(lockout == v[7], $sformatf("R8 case%0d lock", i), lockout, v[7]);
      chk(att == v[6:4], $sformatf("R7 case%0d attempts", i), att, v[6:4]);
      chk(fault_rail == v[3:0], $sformatf("R6 case%0d fault_rail", i), fault_rail, v[3:0]);
      if (i == 0) begin
        chk(rise_t[1] < rise_t[3] && rise_t[3] < rise_t[0] && rise_t[0] < rise_t[2],
            "R5 start order", rise_t[3], rise_t[1]);
        chk(rise_t[3] - rise_t[1] > 6, "R5 slot delay", rise_t[3] - rise_t[1], 7);
        chk(rail_en == 4'hF, "R5 all up", rail_en, 15);
      end
      if (i == 1)
        chk(fall_t[2] < fall_t[0] && fall_t[0] < fall_t[3] && fall_t[3] < fall_t[1],
            "R7 reverse drop", fall_t[2], fall_t[1]);
      if (i == 3) chk(rail_en == 0, "R2 waits", rail_en, 0);
      if (v[7]) begin
        en_pin = 1; cyc_n(100);
        chk(state_code == 1 && rail_en == 0 && lockout, "R8 ignore ON", state_code, 1);
        en_pin = 0; cyc_n(20);
      end
    end

    // R8: POR clears lockout
    do_por();
    chk(lockout == 0 && state_code == 0, "R8 por clear", lockout, 0);

    // R4 / R9: filter in both directions
    fsd_en = 0; retry_max = 0; pg_ok = '1; flt_mask = '0;
    cyc_n(LOAD + 10);
    en_pin = 1; cyc_n(DGL - 1); en_pin = 0; cyc_n(30);
    chk(state_code == 1 && rail_en == 0, "R4 short high", state_code, 1);
    en_pin = 1; cyc_n(DGL + 4);
    chk(state_code == 2, "R4 long high", state_code, 2);
    cyc_n(300);
    chk(state_code == 3, "R5 up", state_code, 3);
    en_pin = 0; cyc_n(DGL - 1); en_pin = 1; cyc_n(30);
    chk(state_code == 3 && rail_en == 4'hF, "R4 short low", state_code, 3);
    en_pin = 0; cyc_n(60);
    chk(state_code == 1 && rail_en == 0 && !lockout, "R9 power down", state_code, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule